// File: doc/BRIEF.md
# TDM Multichannel Slot Selector

This block follows the position of the current element inside a single-phase time-division-multiplexed frame of up to 128 elements. For each element it decides three things. It decides whether a received element is kept. It decides whether the transmitter takes an element for that slot. It decides whether the serial data pin is actively driven or left floating. A surrounding serial port supplies a frame-start strobe, an end-of-element strobe and the static configuration. The block returns three per-element qualifiers and a subframe-boundary pulse.

Two ways of choosing channels are offered. In partitioned mode the frame is cut into eight subframes of 16 adjacent channels. Two partitions each point at one subframe: partition A at an even one, partition B at an odd one. Each partition has its own 16-bit mask, so no more than 32 channels are live at once. In wide mode a single 128-bit mask names each channel directly, and the partition selects are not used. Receive and transmit each have their own copy of this configuration. The transmit side also has a four-way policy that decides how its selection gates loading and pin drive. The subframe-boundary pulse lets a host retarget the partitions while a frame is still running.

Top module: `tdm_slot_sel`

## Requirements
- R1: After a synchronous active-low reset the block is outside a frame, and rx_store, tx_load, dx_oe and subframe_end are all 0.
- R2: A frame_start strobe makes element 0 current from the next cycle. Each elem_done strobe inside a frame moves to the next element. The elem_done that ends element number frame_last closes the frame.
- R3: A frame_start that arrives inside a frame restarts at element 0, and it wins over an elem_done in the same cycle.
- R4: In partitioned mode (wide_mode=0), element e is selected when one of two conditions holds. The first is e/16 == 2*part_a and bit e%16 of mask_a is set. The second is e/16 == 2*part_b+1 and bit e%16 of mask_b is set.
- R5: In wide mode (wide_mode=1), element e is selected exactly when bit e of mask_wide is set, whatever the partition selects hold.
- R6: rx_store is 1 for an element inside a frame when rx_sel_on=0. When rx_sel_on=1 it is 1 only if the receive selection picks that element.
- R7: With tx_mode=2'b00, tx_load and dx_oe are both 1 for every element inside a frame.
- R8: With tx_mode=2'b01, tx_load and dx_oe are 1 only for elements picked by the transmit selection.
- R9: With tx_mode=2'b10, tx_load is 1 for every element inside a frame. dx_oe is 1 only for elements picked by the transmit selection.
- R10: With tx_mode=2'b11, tx_load is 1 only for elements picked by the receive selection. dx_oe is 1 only for elements picked by both the receive and transmit selections.
- R11: subframe_end is a one-cycle pulse in the cycle after an elem_done that ends an in-frame element whose index modulo 16 is 15.
- R12: Between frames, rx_store, tx_load and dx_oe stay 0 in every mode, even while elem_done strobes arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Frame begins; element 0 is current from the next cycle |
| elem_done | input | 1 | Current element has finished |
| frame_last | input | 7 | Index of the final element of a frame |
| wide_mode | input | 1 | 1 selects the 128-bit masks, 0 selects the partitions |
| rx_sel_on | input | 1 | 1 makes reception obey the receive selection |
| tx_mode | input | 2 | Transmit gating policy, codes 00..11 |
| rx_part_a | input | 2 | Receive partition A: even subframe 2*n |
| rx_part_b | input | 2 | Receive partition B: odd subframe 2*n+1 |
| rx_mask_a | input | 16 | Receive channel mask for partition A |
| rx_mask_b | input | 16 | Receive channel mask for partition B |
| rx_mask_wide | input | 128 | Receive channel mask in wide mode |
| tx_part_a | input | 2 | Transmit partition A: even subframe 2*n |
| tx_part_b | input | 2 | Transmit partition B: odd subframe 2*n+1 |
| tx_mask_a | input | 16 | Transmit channel mask for partition A |
| tx_mask_b | input | 16 | Transmit channel mask for partition B |
| tx_mask_wide | input | 128 | Transmit channel mask in wide mode |
| rx_store | output | 1 | Keep the element now being received |
| tx_load | output | 1 | Transmitter takes data for this element |
| dx_oe | output | 1 | Drive the serial data pin for this element |
| subframe_end | output | 1 | A 16-channel subframe has just completed |

## Verification
The whole function hangs on one element index, so any error in it shows up at the ports. An index that is off by one moves every mask bit onto its neighbour. That error is visible at the very next element whose mask bit differs from the one beside it, and at the next subframe pulse, which arrives one element early or late. An in-frame flag that is stuck shows up as qualifiers asserted in the gap after the last element, or as missing qualifiers on element 0. The bench walks whole frames in every transmit policy, so each such fault appears within a few elements.

// File: rtl/tdm_slot_pkg.sv
// Shared types for the TDM slot selector.
// Assumes: the transmit policy is a two-bit code whose values the outside world relies on.
package tdm_slot_pkg;
    typedef enum logic [1:0] {
        TXM_ALL    = 2'b00,
        TXM_SELECT = 2'b01,
        TXM_MASK   = 2'b10,
        TXM_SYMM   = 2'b11
    } tx_mode_e;
endpackage

// File: rtl/tdm_slot_counter.sv
// Element position tracker: holds the current element index and the in-frame flag,
// and raises a pulse when a subframe of SUB_CH channels completes.
// Assumes: the strobes are one cycle wide, and frame_last is below SLOTS.
module tdm_slot_counter #(
    parameter int SLOTS  = 128,
    parameter int SUB_CH = 16,
    localparam int IDXW = $clog2(SLOTS),
    localparam int SUBW = $clog2(SUB_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_start,
    input  logic            elem_done,
    input  logic [IDXW-1:0] frame_last,
    output logic [IDXW-1:0] idx,
    output logic            active,
    output logic            sub_end
);
    localparam logic [IDXW-1:0] IDX_MAX = IDXW'(SLOTS - 1);

    logic sub_last;
    assign sub_last = (idx[SUBW-1:0] == {SUBW{1'b1}});

    // Advance the index; frame_start has priority; the index saturates at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx    <= '0;
            active <= 1'b0;
        end else if (frame_start) begin
            idx    <= '0;
            active <= 1'b1;
        end else if (elem_done && active) begin
            if (idx == frame_last)
                active <= 1'b0;
            else if (idx != IDX_MAX)
                idx <= idx + 1'b1;
        end
    end

    // One-cycle subframe boundary pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sub_end <= 1'b0;
        else
            sub_end <= elem_done && active && !frame_start && sub_last;
    end

    a_r2_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (idx == '0) && active);
    a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_done && active && !frame_start && idx != frame_last && idx != IDX_MAX)
        |=> idx == $past(idx) + 1'b1);
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sub_end |=> !sub_end);
endmodule

// File: rtl/tdm_chan_lookup.sv
// Channel selection lookup: decides whether element idx is selected, either through
// the two 16-channel partitions (A on even subframes, B on odd) or through a wide mask.
// Assumes: SLOTS / SUB_CH is even, so the partitions pair up the subframes.
module tdm_chan_lookup #(
    parameter int SLOTS  = 128,
    parameter int SUB_CH = 16,
    localparam int IDXW  = $clog2(SLOTS),
    localparam int SUBW  = $clog2(SUB_CH),
    localparam int NSUB  = SLOTS / SUB_CH,
    localparam int PSELW = $clog2(NSUB / 2)
) (
    input  logic [IDXW-1:0]   idx,
    input  logic              wide_mode,
    input  logic [PSELW-1:0]  part_a,
    input  logic [PSELW-1:0]  part_b,
    input  logic [SUB_CH-1:0] mask_a,
    input  logic [SUB_CH-1:0] mask_b,
    input  logic [SLOTS-1:0]  mask_wide,
    output logic              hit
);
    logic [IDXW-SUBW-1:0] sub_no;
    logic [SUBW-1:0]      pos;
    logic [NSUB-1:0]      sub_hit;

    assign sub_no = idx[IDXW-1:SUBW];
    assign pos    = idx[SUBW-1:0];

    // Per-subframe decision: even subframes are owned by A, odd ones by B.
    for (genvar s = 0; s < NSUB; s++) begin : g_sub
        if (s % 2 == 0) begin : g_even
            assign sub_hit[s] = (part_a == PSELW'(s / 2)) && mask_a[pos];
        end else begin : g_odd
            assign sub_hit[s] = (part_b == PSELW'(s / 2)) && mask_b[pos];
        end
    end

    // Pick the wide mask or the partition result for the current element.
    always_comb begin
        if (wide_mode)
            hit = mask_wide[idx];
        else
            hit = sub_hit[sub_no];
    end
endmodule

// File: rtl/tdm_tx_gate.sv
// Qualifier gating: turns the in-frame flag and the receive and transmit selections
// into the store, load and pin-drive qualifiers under the chosen transmit policy.
// Assumes: the hit inputs belong to the current element.
module tdm_tx_gate
    import tdm_slot_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     active,
    input  logic     rx_sel_on,
    input  tx_mode_e mode,
    input  logic     rx_hit,
    input  logic     tx_hit,
    output logic     rx_store,
    output logic     tx_load,
    output logic     dx_oe
);
    // Receive keep decision.
    always_comb rx_store = active && (!rx_sel_on || rx_hit);

    // Transmit load and pin drive per policy.
    always_comb begin
        unique case (mode)
            TXM_ALL: begin
                tx_load = active;
                dx_oe   = active;
            end
            TXM_SELECT: begin
                tx_load = active && tx_hit;
                dx_oe   = active && tx_hit;
            end
            TXM_MASK: begin
                tx_load = active;
                dx_oe   = active && tx_hit;
            end
            default: begin
                tx_load = active && rx_hit;
                dx_oe   = active && rx_hit && tx_hit;
            end
        endcase
    end

    a_r9_drive_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        dx_oe |-> tx_load);
    a_r10_symm_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TXM_SYMM && tx_load) |-> rx_hit);
endmodule

// File: rtl/tdm_slot_sel.sv
// TDM multichannel slot selector top: an element tracker, two channel lookups
// (receive and transmit) and the qualifier gating.
// Assumes: the configuration is steady while it is in use, except the partition
// selects, which may change at subframe boundaries.
module tdm_slot_sel
    import tdm_slot_pkg::*;
#(
    parameter int SLOTS  = 128,
    parameter int SUB_CH = 16,
    localparam int IDXW  = $clog2(SLOTS),
    localparam int PSELW = $clog2(SLOTS / SUB_CH / 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              elem_done,
    input  logic [IDXW-1:0]   frame_last,
    input  logic              wide_mode,
    input  logic              rx_sel_on,
    input  logic [1:0]        tx_mode,
    input  logic [PSELW-1:0]  rx_part_a,
    input  logic [PSELW-1:0]  rx_part_b,
    input  logic [SUB_CH-1:0] rx_mask_a,
    input  logic [SUB_CH-1:0] rx_mask_b,
    input  logic [SLOTS-1:0]  rx_mask_wide,
    input  logic [PSELW-1:0]  tx_part_a,
    input  logic [PSELW-1:0]  tx_part_b,
    input  logic [SUB_CH-1:0] tx_mask_a,
    input  logic [SUB_CH-1:0] tx_mask_b,
    input  logic [SLOTS-1:0]  tx_mask_wide,
    output logic              rx_store,
    output logic              tx_load,
    output logic              dx_oe,
    output logic              subframe_end
);
    logic [IDXW-1:0] idx;
    logic            active;
    logic            rx_hit;
    logic            tx_hit;

    tdm_slot_counter #(.SLOTS(SLOTS), .SUB_CH(SUB_CH)) u_cnt (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .elem_done(elem_done),
        .frame_last(frame_last), .idx(idx), .active(active), .sub_end(subframe_end)
    );

    tdm_chan_lookup #(.SLOTS(SLOTS), .SUB_CH(SUB_CH)) u_rx_lkp (
        .idx(idx), .wide_mode(wide_mode), .part_a(rx_part_a), .part_b(rx_part_b),
        .mask_a(rx_mask_a), .mask_b(rx_mask_b), .mask_wide(rx_mask_wide), .hit(rx_hit)
    );

    tdm_chan_lookup #(.SLOTS(SLOTS), .SUB_CH(SUB_CH)) u_tx_lkp (
        .idx(idx), .wide_mode(wide_mode), .part_a(tx_part_a), .part_b(tx_part_b),
        .mask_a(tx_mask_a), .mask_b(tx_mask_b), .mask_wide(tx_mask_wide), .hit(tx_hit)
    );

    tdm_tx_gate u_gate (
        .clk(clk), .rst_n(rst_n), .active(active), .rx_sel_on(rx_sel_on),
        .mode(tx_mode_e'(tx_mode)), .rx_hit(rx_hit), .tx_hit(tx_hit),
        .rx_store(rx_store), .tx_load(tx_load), .dx_oe(dx_oe)
    );

    a_r12_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !rx_store && !tx_load && !dx_oe);
    a_r11_pulse_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        subframe_end |-> $past(elem_done) && $past(active));
endmodule

// File: tb/tdm_slot_sel_tb.sv
module tdm_slot_sel_tb_top;
    localparam int CLK_HALF = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         frame_start = 1'b0;
    logic         elem_done = 1'b0;
    logic [6:0]   frame_last = '0;
    logic         wide_mode = 1'b0;
    logic         rx_sel_on = 1'b0;
    logic [1:0]   tx_mode = 2'b00;
    logic [1:0]   rx_part_a = '0, rx_part_b = '0, tx_part_a = '0, tx_part_b = '0;
    logic [15:0]  rx_mask_a = '0, rx_mask_b = '0, tx_mask_a = '0, tx_mask_b = '0;
    logic [127:0] rx_mask_wide = '0, tx_mask_wide = '0;
    logic         rx_store, tx_load, dx_oe, subframe_end;

    tdm_slot_sel dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .elem_done(elem_done),
        .frame_last(frame_last), .wide_mode(wide_mode), .rx_sel_on(rx_sel_on),
        .tx_mode(tx_mode), .rx_part_a(rx_part_a), .rx_part_b(rx_part_b),
        .rx_mask_a(rx_mask_a), .rx_mask_b(rx_mask_b), .rx_mask_wide(rx_mask_wide),
        .tx_part_a(tx_part_a), .tx_part_b(tx_part_b), .tx_mask_a(tx_mask_a),
        .tx_mask_b(tx_mask_b), .tx_mask_wide(tx_mask_wide),
        .rx_store(rx_store), .tx_load(tx_load), .dx_oe(dx_oe), .subframe_end(subframe_end)
    );

    always #(CLK_HALF) clk = ~clk;

    int total = 0;
    int bad = 0;
    bit driver_done = 1'b0;
    logic [3:0] exp_q[$];
    string tag_q[$];
    string txr_q[$];
    event smp_ev;

    // Bench model of the element position (R2, R3).
    int m_idx = 0;
    bit m_act = 1'b0;

    // Selection model per R4 / R5.
    function automatic bit sel(bit wide, logic [1:0] pa, logic [1:0] pb,
                               logic [15:0] ma, logic [15:0] mb, logic [127:0] mw, int e);
        if (wide) return mw[e];
        if (e / 16 == 2 * pa && ma[e % 16]) return 1'b1;
        if (e / 16 == 2 * pb + 1 && mb[e % 16]) return 1'b1;
        return 1'b0;
    endfunction

    task automatic push_exp(bit eo, string tag);
        bit rh, th, rs, tl, oe;
        string tr;
        rh = sel(wide_mode, rx_part_a, rx_part_b, rx_mask_a, rx_mask_b, rx_mask_wide, m_idx);
        th = sel(wide_mode, tx_part_a, tx_part_b, tx_mask_a, tx_mask_b, tx_mask_wide, m_idx);
        rs = m_act && (!rx_sel_on || rh);
        case (tx_mode)
            2'b00: begin tl = m_act;      oe = m_act;            tr = "R7";  end
            2'b01: begin tl = m_act && th; oe = m_act && th;     tr = "R8";  end
            2'b10: begin tl = m_act;      oe = m_act && th;      tr = "R9";  end
            default: begin tl = m_act && rh; oe = m_act && rh && th; tr = "R10"; end
        endcase
        if (!m_act) tr = "R12";
        exp_q.push_back({rs, tl, oe, eo});
        tag_q.push_back(tag);
        txr_q.push_back(tr);
        ->smp_ev;
    endtask

    // Driver: apply one cycle of strobes, update the model, push expected outputs.
    task automatic step(bit fs, bit ed, string tag);
        bit eo;
        @(negedge clk);
        frame_start = fs;
        elem_done = ed;
        @(posedge clk);
        #1;
        frame_start = 1'b0;
        elem_done = 1'b0;
        eo = ed && m_act && !fs && (m_idx % 16 == 15);
        if (fs) begin
            m_idx = 0;
            m_act = 1'b1;
        end else if (ed && m_act) begin
            if (m_idx == int'(frame_last)) m_act = 1'b0;
            else if (m_idx != 127) m_idx++;
        end
        #4;
        push_exp(eo, tag);
    endtask

    task automatic run_frame(int last, string tag);
        frame_last = 7'(last);
        step(1'b1, 1'b0, tag);
        for (int k = 0; k <= last; k++) step(1'b0, 1'b1, tag);
        step(1'b0, 1'b0, tag);
    endtask

    task automatic chk(string req, string tag, bit act, bit ex);
        total++;
        if (act !== ex) begin
            bad++;
            $display("FAIL %s (%s) elem=%0d act=%0b exp=%0b", req, tag, m_idx, act, ex);
        end
    endtask

    // Monitor: pop expected items and compare with the outputs.
    initial begin
        forever begin
            @(smp_ev);
            while (exp_q.size() > 0) begin
                logic [3:0] e;
                string tg, tr;
                e = exp_q.pop_front();
                tg = tag_q.pop_front();
                tr = txr_q.pop_front();
                chk("R6 rx_store", tg, rx_store, e[3]);
                chk({tr, " tx_load"}, tg, tx_load, e[2]);
                chk({tr, " dx_oe"}, tg, dx_oe, e[1]);
                chk("R11 subframe_end", tg, subframe_end, e[0]);
            end
        end
    end

    // Watchdog.
    initial begin
        #(2 * CLK_HALF * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        // R1: reset state, in the all-drive mode so a leak would be visible.
        push_exp(1'b0, "R1");
        @(negedge clk);
        rst_n = 1'b1;

        // R4 partitioned: rx A->subframe 2, B->subframe 1; tx masks are subsets.
        rx_part_a = 2'd1; rx_part_b = 2'd0; rx_mask_a = 16'hA5C3; rx_mask_b = 16'h0F0F;
        tx_part_a = 2'd1; tx_part_b = 2'd0; tx_mask_a = 16'h8541; tx_mask_b = 16'h0306;
        rx_sel_on = 1'b1;
        for (int m = 0; m < 4; m++) begin
            tx_mode = 2'(m);
            run_frame(47, "R4 R2");
        end

        // R4 other partitions, covering subframes 5 and 6, select policy.
        rx_part_a = 2'd3; rx_part_b = 2'd2; tx_part_a = 2'd3; tx_part_b = 2'd2;
        tx_mask_a = 16'h00FF; tx_mask_b = 16'hF00F;
        tx_mode = 2'b01;
        run_frame(127, "R4 high");

        // R6: receive selection off stores every in-frame element.
        rx_sel_on = 1'b0;
        tx_mode = 2'b11;
        run_frame(20, "R6 off");
        rx_sel_on = 1'b1;

        // R3: restart mid-frame, also with a simultaneous elem_done.
        tx_mode = 2'b00;
        frame_last = 7'd30;
        step(1'b1, 1'b0, "R3");
        for (int k = 0; k < 18; k++) step(1'b0, 1'b1, "R3");
        step(1'b1, 1'b1, "R3 both");
        for (int k = 0; k < 31; k++) step(1'b0, 1'b1, "R3");

        // R12: strobes in the gap produce nothing.
        for (int k = 0; k < 5; k++) step(1'b0, 1'b1, "R12 gap");

        // R5: wide masks; partitions left pointing elsewhere.
        wide_mode = 1'b1;
        rx_mask_wide = {32'h9E3779B9, 32'h7F4A7C15, 32'hF39CC060, 32'h5CEDC834};
        tx_mask_wide = rx_mask_wide & {32'hFFFF0000, 32'h0F0F0F0F, 32'hAAAAAAAA, 32'h3C3C3C3C};
        for (int m = 0; m < 4; m++) begin
            tx_mode = 2'(m);
            run_frame(127, "R5");
        end
        rx_sel_on = 1'b0;
        tx_mode = 2'b10;
        run_frame(63, "R5 R6");

        driver_done = 1'b1;
        repeat (3) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule